// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a 32-pin general-purpose I/O register set on a simple word-addressed register bus. Each pin has a direction bit and an output latch. Software changes the latch only through write-one set and clear ports, so two agents can update different pins without a read-modify-write sequence. The pin levels pass through a two-flop synchronizer and can be read back whether the pin is driven or not. Because of the synchronizer, a read taken right after an output change can still return the old level.

Each pin has its own rising-edge and falling-edge enables, which are also changed through set and clear ports. An enabled edge sets a sticky status bit, and software clears that bit by writing 1 to it. The status bits of pins 0–15 drive interrupt line 0 and those of pins 16–31 drive line 1. Each line is gated by its own bit in a line-enable register. The lines are levels, so they stay high until their status bits are cleared.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, direction (0x00) reads 0xFFFFFFFF (all inputs) and the output latch (0x04) reads 0. Both edge-enable masks, the status register (0x24) and the line-enable register (0x28) read 0, and both interrupt lines are low.
- R2: A direction bit of 1 makes the pin an input and a bit of 0 makes it an output. `pin_oe` is the bitwise inverse of the direction register, and `pin_out` follows the output latch.
- R3: Writing 1s to 0x08 sets those latch bits, and writing 1s to 0x0C clears them. Bits written as 0 keep their value. The latch reads back at 0x04, 0x08 and 0x0C.
- R4: Offset 0x10 returns the pin level after two synchronizer flops. A level driven before a clock edge is not visible at the next bus read, and is visible one edge later.
- R5: Writing 1s to 0x14 or 0x1C enables rising or falling detection on those pins, and writing 1s to 0x18 or 0x20 disables it. Zero bits keep their value. 0x14 and 0x18 read the rising mask, and 0x1C and 0x20 read the falling mask.
- R6: A 0→1 change of the synchronized level on a pin with the rising enable set, or a 1→0 change on a pin with the falling enable set, sets that pin's bit at 0x24. A pin with both enables set reports either edge. Disabled polarities and steady pins set nothing.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Status bits are never cleared any other way.
- R8: Line 0 is high exactly when status bits 15:0 are not all zero and line-enable bit 0 (register 0x28) is 1. Line 1 is high likewise for bits 31:16 and line-enable bit 1.
- R9: If an edge event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: Reads of offsets with no register, and reads with `bus_en` low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output latch to the pads |
| pin_oe | output | 32 | Per-pin output enable, 1 = drive |
| irq_bank | output | 2 | Line-gated interrupt levels, one per 16-pin half |

## Verification
The edge detector is driven with a table of enable masks and before/after pin patterns. The patterns cover rising-only, falling-only and both-edge pins, mixed polarities on alternate pins, a steady bus and all-disabled enables. Together they separate polarity selection from change detection and show that a steady or disabled pin stays silent. Directed cases cover the synchronizer delay on readback and the gating of each half-bank line on its own. They also cover a clear that lands in the same cycle as a new edge, and the set/clear ports with zero bits.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int NPINS  = 32,
  parameter int HALF   = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS/HALF-1:0] irq_bank
);
  localparam int NLINE = NPINS / HALF;

  localparam logic [ADDR_W-1:0] A_DIR  = 6'h00;
  localparam logic [ADDR_W-1:0] A_OUT  = 6'h04;
  localparam logic [ADDR_W-1:0] A_OSET = 6'h08;
  localparam logic [ADDR_W-1:0] A_OCLR = 6'h0C;
  localparam logic [ADDR_W-1:0] A_IN   = 6'h10;
  localparam logic [ADDR_W-1:0] A_RSET = 6'h14;
  localparam logic [ADDR_W-1:0] A_RCLR = 6'h18;
  localparam logic [ADDR_W-1:0] A_FSET = 6'h1C;
  localparam logic [ADDR_W-1:0] A_FCLR = 6'h20;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h24;
  localparam logic [ADDR_W-1:0] A_LEN  = 6'h28;

  logic [NPINS-1:0] dir, out_lat, rise_en, fall_en, status;
  logic [NPINS-1:0] sync1, sync2, hist;
  logic [NLINE-1:0] bank_en;
  logic [NPINS-1:0] evt;
  logic             wr;

  assign wr = bus_en & bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      hist  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      hist  <= sync2;
    end
  end

  assign evt = (sync2 & ~hist & rise_en) | (~sync2 & hist & fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir     <= '1;
      out_lat <= '0;
      rise_en <= '0;
      fall_en <= '0;
      status  <= '0;
      bank_en <= '0;
    end else begin
      if (wr && bus_addr == A_DIR)  dir     <= bus_wdata;
      if (wr && bus_addr == A_OSET) out_lat <= out_lat | bus_wdata;
      if (wr && bus_addr == A_OCLR) out_lat <= out_lat & ~bus_wdata;
      if (wr && bus_addr == A_RSET) rise_en <= rise_en | bus_wdata;
      if (wr && bus_addr == A_RCLR) rise_en <= rise_en & ~bus_wdata;
      if (wr && bus_addr == A_FSET) fall_en <= fall_en | bus_wdata;
      if (wr && bus_addr == A_FCLR) fall_en <= fall_en & ~bus_wdata;
      if (wr && bus_addr == A_LEN)  bank_en <= bus_wdata[NLINE-1:0];
      if (wr && bus_addr == A_STAT) status  <= (status & ~bus_wdata) | evt;
      else                          status  <= status | evt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        A_DIR:                bus_rdata = dir;
        A_OUT, A_OSET, A_OCLR: bus_rdata = out_lat;
        A_IN:                 bus_rdata = sync2;
        A_RSET, A_RCLR:       bus_rdata = rise_en;
        A_FSET, A_FCLR:       bus_rdata = fall_en;
        A_STAT:               bus_rdata = status;
        A_LEN:                bus_rdata = {{(NPINS-NLINE){1'b0}}, bank_en};
        default:              bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_lat;
  assign pin_oe  = ~dir;

  for (genvar b = 0; b < NLINE; b++) begin : g_line
    assign irq_bank[b] = bank_en[b] & (|status[b*HALF +: HALF]);
  end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int NPINS  = 32,
  parameter int NLINE  = 2,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NLINE-1:0]  irq_bank,
  input logic [NLINE-1:0]  bank_en,
  input logic [NPINS-1:0]  status,
  input logic [NPINS-1:0]  out_lat,
  input logic [NPINS-1:0]  rise_en,
  input logic [NPINS-1:0]  fall_en
);
  // R8
  irq0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_bank[0] |-> bank_en[0]);
  // R8
  irq1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_bank[1] |-> bank_en[1]);
  // R7
  sticky_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we && bus_addr == 6'h24) |=> ((status & $past(status)) == $past(status)));
  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we && (bus_addr == 6'h08 || bus_addr == 6'h0C)) |=> $stable(out_lat));
  // R5
  rmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we && (bus_addr == 6'h14 || bus_addr == 6'h18)) |=> $stable(rise_en));
  // R6
  no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_en | fall_en) == '0) |=> ((status & ~$past(status)) == '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS), .NLINE(NLINE), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .irq_bank(irq_bank), .bank_en(bank_en), .status(status), .out_lat(out_lat),
  .rise_en(rise_en), .fall_en(fall_en));

// File: tb/gpio_edge_bank_tb_top.sv
module gpio_edge_bank_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic [1:0]  irq_bank;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_edge_bank dut_i (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_bank(irq_bank));

  // {rise_en, fall_en, start, end, expected status}
  localparam logic [159:0] VEC [6] = '{
    {32'h0000FFFF, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h0000FFFF},
    {32'h00000000, 32'hFFFF0000, 32'hFFFFFFFF, 32'h00000000, 32'hFFFF0000},
    {32'h0F0F0F0F, 32'h0F0F0F0F, 32'h00FF00FF, 32'hFF00FF00, 32'h0F0F0F0F},
    {32'hAAAAAAAA, 32'h55555555, 32'h00000000, 32'hFFFFFFFF, 32'hAAAAAAAA},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12345678, 32'h12345678, 32'h00000000},
    {32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    rd(6'h00, v); chk("R1 dir", v, 32'hFFFFFFFF);
    rd(6'h04, v); chk("R1 out", v, 0);
    rd(6'h14, v); chk("R1 rise", v, 0);
    rd(6'h1C, v); chk("R1 fall", v, 0);
    rd(6'h24, v); chk("R1 stat", v, 0);
    rd(6'h28, v); chk("R1 len", v, 0);
    chk("R1 irq", {30'd0, irq_bank}, 0);

    // R6 edge table
    for (int i = 0; i < 6; i++) begin
      wr(6'h18, '1); wr(6'h20, '1);
      pin_in = VEC[i][95:64]; idle(4);
      wr(6'h14, VEC[i][159:128]); wr(6'h1C, VEC[i][127:96]);
      wr(6'h24, '1);
      pin_in = VEC[i][63:32]; idle(4);
      rd(6'h24, v); chk($sformatf("R6 vec%0d", i), v, VEC[i][31:0]);
    end

    // R2 direction
    wr(6'h00, 32'h0000FFFF);
    chk("R2 oe", pin_oe, 32'hFFFF0000);
    // R3 set/clear latch
    wr(6'h08, 32'h0000F0F0); wr(6'h0C, 32'h000000F0);
    rd(6'h04, v); chk("R3 latch", v, 32'h0000F000);
    chk("R2 pin_out", pin_out, 32'h0000F000);
    wr(6'h08, 0); wr(6'h0C, 0);
    rd(6'h0C, v); chk("R3 zero bits", v, 32'h0000F000);

    // R5 mask read-back
    wr(6'h18, '1); wr(6'h20, '1);
    wr(6'h14, 32'h00FF00FF); wr(6'h18, 32'h000000F0);
    rd(6'h18, v); chk("R5 rise", v, 32'h00FF000F);
    wr(6'h1C, 32'h11110000); wr(6'h20, 0);
    rd(6'h20, v); chk("R5 fall", v, 32'h11110000);

    // R4 synchronizer delay
    pin_in = 32'h0; idle(4);
    pin_in = 32'hC0DE0001;
    @(negedge clk); rd(6'h10, v); chk("R4 old", v, 32'h0);
    @(negedge clk); rd(6'h10, v); chk("R4 new", v, 32'hC0DE0001);

    // R7 W1C and R8 line gating
    wr(6'h18, '1); wr(6'h20, '1); wr(6'h24, '1);
    wr(6'h14, 32'h00010001);
    pin_in = 0; idle(4); pin_in = 32'h00010001; idle(4);
    rd(6'h24, v); chk("R6 both halves", v, 32'h00010001);
    chk("R8 gated off", {30'd0, irq_bank}, 0);
    wr(6'h28, 32'h1);
    chk("R8 line0 only", {30'd0, irq_bank}, 32'h1);
    wr(6'h28, 32'h3);
    chk("R8 both", {30'd0, irq_bank}, 32'h3);
    wr(6'h24, 0);
    rd(6'h24, v); chk("R7 zero write", v, 32'h00010001);
    wr(6'h24, 32'h00000001);
    rd(6'h24, v); chk("R7 clear", v, 32'h00010000);
    chk("R8 line0 drops", {30'd0, irq_bank}, 32'h2);

    // R9 event beats clear in same cycle
    pin_in = 0; idle(4);
    wr(6'h24, '1);
    wr(6'h14, 32'h00000002);
    pin_in = 32'h2; idle(4);
    rd(6'h24, v); chk("R9 pre", v, 32'h2);
    pin_in = 0; idle(4);
    wr(6'h1C, 32'h00000002);
    pin_in = 32'h2;
    @(negedge clk);
    pin_in = 0;
    wr(6'h24, 32'h2);
    rd(6'h24, v); chk("R9 event wins", v, 32'h2);

    // R10 undefined offsets
    rd(6'h2C, v); chk("R10 hole", v, 0);
    rd(6'h3C, v); chk("R10 top", v, 0);
    bus_addr = 6'h00; #1 chk("R10 no strobe", bus_rdata, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule